// File: doc/BRIEF.md
# Identity-Gated Cipher Key Register Bank

This block stores a 128-bit symmetric cipher key as four 32-bit words behind a small register bus. Every bus access carries the identity of the requesting agent. Two independent policy registers decide whether that identity may fetch key words and whether it may change them. Each policy is a bitmask with one bit per identity.

Keeping the permissions for fetching and for changing the key in separate registers lets a crypto engine consume the key without being able to alter it. It also lets trusted firmware provision the key without being able to read it back. The whole key is driven continuously on a side output for the cipher datapath. Bus responses (read data and error) are registered, so they appear one clock after the strobe. Writes take effect on the same edge that registers the response.

Top module: `key_vault_regs`

## Requirements
- R1: After reset, every key word reads as 0x00000000, `key_o` is all zeros, the fetch policy holds 0x00000002 and the change policy holds 0x00000004.
- R2: Word offset k (0 to 3) holds `key_o` bits [32k+31:32k]. Offset 4 is the fetch policy, offset 5 is the change policy, and offsets 6 and 7 are unmapped.
- R3: A read of a key word by agent N succeeds only when bit N of the fetch policy is set. The word is then returned on `rdata_o` one cycle after the strobe, with `err_o` low.
- R4: A refused read returns zero on `rdata_o` and raises `err_o` for exactly that one response cycle. No key bits ever appear on `rdata_o`.
- R5: A write to a key word by agent N succeeds only when bit N of the change policy is set. The word and `key_o` are updated on the next clock edge.
- R6: A refused write leaves every key word and both policies unchanged and raises `err_o` in the response cycle.
- R7: The two policies are checked separately. With reset values, agent 2 cannot read key words and agent 1 cannot write them.
- R8: Either policy register may be written only by an agent whose change-policy bit is set. Any agent may read either policy back.
- R9: An access to an unmapped offset returns zero with `err_o` set and changes no state.
- R10: When `rd_i` and `wr_i` are both high, the access is handled as a write only, and `rdata_o` is zero in the response cycle.
- R11: In a cycle with no strobe, the following response has `err_o` low and `rdata_o` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Word offset inside the bank |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| agent_i | input | 5 | Identity of the requesting agent |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Registered error response |
| key_o | output | 128 | Assembled key for the cipher engine |

## Verification
The bench builds the block with its default parameters: four key words, 32-bit data, 5-bit identities and a 3-bit offset. With these values all 32 identities map onto policy bits, so a sweep over every identity checks that exactly the permitted bits grant access. The 3-bit offset space leaves two unmapped offsets reachable, so the error path for holes in the map is exercised alongside refusals by policy. Policies are rewritten during the run to confirm that fetch and change rights move independently of each other.

// File: rtl/key_vault_pkg.sv
package key_vault_pkg;
  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_RPOL = 2'd1,
    SEL_WPOL = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  function automatic sel_e decode_sel(input int unsigned off, input int unsigned key_words);
    if (off < key_words)           return SEL_KEY;
    else if (off == key_words)     return SEL_RPOL;
    else if (off == key_words + 1) return SEL_WPOL;
    else                           return SEL_NONE;
  endfunction
endpackage

// File: rtl/kv_access_check.sv
module kv_access_check
  import key_vault_pkg::*;
#(
  parameter int unsigned AGENT_W = 5,
  parameter int unsigned POL_W   = 1 << AGENT_W
) (
  input  logic [POL_W-1:0]   rd_pol_i,
  input  logic [POL_W-1:0]   wr_pol_i,
  input  logic [AGENT_W-1:0] agent_i,
  input  sel_e               sel_i,
  input  logic               rd_i,
  input  logic               wr_i,
  output logic               rd_ok_o,
  output logic               wr_ok_o,
  output logic               deny_o
);
  logic rd_bit, wr_bit, rd_allow, wr_allow;

  assign rd_bit   = rd_pol_i[agent_i];
  assign wr_bit   = wr_pol_i[agent_i];
  // policies themselves are readable by all; key words need the fetch bit
  assign rd_allow = (sel_i == SEL_KEY) ? rd_bit : (sel_i != SEL_NONE);
  assign wr_allow = (sel_i != SEL_NONE) && wr_bit;

  assign wr_ok_o  = wr_i && wr_allow;
  assign rd_ok_o  = rd_i && !wr_i && rd_allow;
  assign deny_o   = wr_i ? !wr_allow : (rd_i && !rd_allow);

  always_comb begin
    AST_GRANT_EXCLUSIVE: assert ($onehot0({rd_ok_o, wr_ok_o})); // R10
  end
endmodule

// File: rtl/kv_policy_reg.sv
module kv_policy_reg #(
  parameter int unsigned       W       = 32,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pol_o <= RST_VAL;
    else if (we_i) pol_o <= wdata_i;
  end
endmodule

// File: rtl/kv_key_store.sv
module kv_key_store #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned KEY_WORDS = 4,
  localparam int unsigned KEY_W    = DATA_W * KEY_WORDS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [KEY_WORDS-1:0] we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [KEY_W-1:0]     key_o
);
  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (we_i[k]) word_q <= wdata_i;
    end
    assign key_o[k*DATA_W +: DATA_W] = word_q;
  end

  always_comb begin
    AST_ONE_WORD_WE: assert ($onehot0(we_i)); // R2
  end
endmodule

// File: rtl/key_vault_regs.sv
module key_vault_regs
  import key_vault_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned KEY_WORDS  = 4,
  parameter int unsigned AGENT_W    = 5,
  parameter int unsigned ADDR_W     = 3,
  parameter logic [31:0] RD_POL_RST = 32'h0000_0002,
  parameter logic [31:0] WR_POL_RST = 32'h0000_0004,
  localparam int unsigned KEY_W     = DATA_W * KEY_WORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [AGENT_W-1:0] agent_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o,
  output logic [KEY_W-1:0]   key_o
);
  sel_e                 sel;
  logic                 rd_ok, wr_ok, deny;
  logic [DATA_W-1:0]    rd_pol, wr_pol, rd_mux;
  logic [KEY_WORDS-1:0] key_we;

  assign sel = decode_sel(int'(addr_i), KEY_WORDS);

  kv_access_check #(.AGENT_W(AGENT_W), .POL_W(DATA_W)) u_check (
    .rd_pol_i (rd_pol),
    .wr_pol_i (wr_pol),
    .agent_i  (agent_i),
    .sel_i    (sel),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .rd_ok_o  (rd_ok),
    .wr_ok_o  (wr_ok),
    .deny_o   (deny)
  );

  kv_policy_reg #(.W(DATA_W), .RST_VAL(DATA_W'(RD_POL_RST))) u_rd_pol (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok && sel == SEL_RPOL),
    .wdata_i (wdata_i),
    .pol_o   (rd_pol)
  );

  kv_policy_reg #(.W(DATA_W), .RST_VAL(DATA_W'(WR_POL_RST))) u_wr_pol (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok && sel == SEL_WPOL),
    .wdata_i (wdata_i),
    .pol_o   (wr_pol)
  );

  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_we
    assign key_we[k] = wr_ok && (sel == SEL_KEY) && (int'(addr_i) == k);
  end

  kv_key_store #(.DATA_W(DATA_W), .KEY_WORDS(KEY_WORDS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (key_we),
    .wdata_i (wdata_i),
    .key_o   (key_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_RPOL: rd_mux = rd_pol;
      SEL_WPOL: rd_mux = wr_pol;
      SEL_KEY: begin
        for (int k = 0; k < KEY_WORDS; k++)
          if (int'(addr_i) == k) rd_mux = key_o[k*DATA_W +: DATA_W];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rd_ok ? rd_mux : '0;
      err_o   <= deny;
    end
  end

  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0); // R4
  AST_DENIED_WR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_ok) |=> ($stable(key_o) && $stable(rd_pol) && $stable(wr_pol) && err_o)); // R6
  AST_DENIED_RD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !rd_ok) |=> (err_o && rdata_o == '0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |=> (!err_o && rdata_o == '0)); // R11
  AST_WR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rdata_o == '0); // R10
  AST_UNMAPPED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && sel == SEL_NONE) |=> (err_o && $stable(key_o))); // R9
endmodule

// File: tb/key_vault_regs_tb.sv
`timescale 1ns/1ps
module key_vault_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [4:0]  agent = '0;
  logic [31:0] rdata;
  logic        err;
  logic [127:0] key;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_key [4];
  logic [31:0] got_d;
  logic        got_e;

  always #2.5 clk = ~clk;

  key_vault_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .agent_i(agent), .rdata_o(rdata), .err_o(err), .key_o(key)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus cycle; response sampled 1ns after the registering edge
  task automatic bus(input bit r, input bit w, input logic [2:0] a, input logic [4:0] id, input logic [31:0] d);
    @(negedge clk);
    rd = r; wr = w; addr = a; agent = id; wdata = d;
    @(posedge clk); #1;
    got_d = rdata; got_e = err;
    @(negedge clk);
    rd = 0; wr = 0;
  endtask

  task automatic idle_chk(input string req);
    @(posedge clk); #1;
    chk(err == 0 && rdata == 0, req, {rdata, 3'b0, err}, 0);
  endtask

  function automatic logic [127:0] model_key();
    return {exp_key[3], exp_key[2], exp_key[1], exp_key[0]};
  endfunction

  task automatic t_reset();
    chk(key == 0, "R1 key_o", key, 0);
    chk(err == 0 && rdata == 0, "R1 outputs", {rdata, err}, 0);
    for (int k = 0; k < 4; k++) begin
      bus(1, 0, 3'(k), 5'd1, 0);
      chk(got_d == 0 && !got_e, "R1 key word", got_d, 0);
    end
    bus(1, 0, 3'd4, 5'd9, 0);
    chk(got_d == 32'h2 && !got_e, "R1 fetch policy", got_d, 32'h2);
    bus(1, 0, 3'd5, 5'd9, 0);
    chk(got_d == 32'h4 && !got_e, "R1/R8 change policy", got_d, 32'h4);
  endtask

  task automatic t_write_read();
    for (int k = 0; k < 4; k++) begin
      exp_key[k] = 32'hA5C3_0000 + 32'(k * 32'h1111);
      bus(0, 1, 3'(k), 5'd2, exp_key[k]);
      chk(!got_e && got_d == 0, "R5 write ok", {got_d, got_e}, 0);
      chk(key[k*32 +: 32] == exp_key[k], "R2/R5 key_o slice", key[k*32 +: 32], exp_key[k]);
    end
    chk(key == model_key(), "R2 key_o whole", key, model_key());
    for (int k = 0; k < 4; k++) begin
      bus(1, 0, 3'(k), 5'd1, 0);
      chk(got_d == exp_key[k] && !got_e, "R3 read ok", got_d, exp_key[k]);
    end
  endtask

  task automatic t_denied();
    bus(1, 0, 3'd1, 5'd2, 0);
    chk(got_e && got_d == 0, "R4/R7 writer cannot read", {got_d, got_e}, 1);
    idle_chk("R4 err one cycle");
    bus(0, 1, 3'd1, 5'd1, 32'hDEAD_BEEF);
    chk(got_e, "R6/R7 reader cannot write", got_e, 1);
    chk(key == model_key(), "R6 key unchanged", key, model_key());
    bus(0, 1, 3'd4, 5'd1, 32'hFFFF_FFFF);
    chk(got_e, "R8 policy write refused", got_e, 1);
    bus(1, 0, 3'd4, 5'd1, 0);
    chk(got_d == 32'h2, "R6/R8 policy unchanged", got_d, 32'h2);
    idle_chk("R11 idle");
  endtask

  task automatic t_sweep();
    for (int id = 0; id < 32; id++) begin
      bus(1, 0, 3'd0, 5'(id), 0);
      if (id == 1) chk(got_d == exp_key[0] && !got_e, "R3 sweep grant", got_d, exp_key[0]);
      else         chk(got_d == 0 && got_e, "R3/R4 sweep deny", {got_d, got_e}, 1);
    end
  endtask

  task automatic t_policy_update();
    bus(0, 1, 3'd4, 5'd2, 32'h0000_8000); // fetch moves to id 15
    chk(!got_e, "R8 fetch policy write", got_e, 0);
    bus(1, 0, 3'd2, 5'd1, 0);
    chk(got_e && got_d == 0, "R3 old reader refused", {got_d, got_e}, 1);
    bus(1, 0, 3'd2, 5'd15, 0);
    chk(got_d == exp_key[2] && !got_e, "R3 new reader", got_d, exp_key[2]);
    bus(0, 1, 3'd5, 5'd2, 32'h8000_0000); // change moves to id 31
    chk(!got_e, "R8 change policy write", got_e, 0);
    bus(0, 1, 3'd3, 5'd2, 32'h1);
    chk(got_e && key == model_key(), "R5/R6 old writer refused", key, model_key());
    exp_key[3] = 32'h0BAD_F00D;
    bus(0, 1, 3'd3, 5'd31, exp_key[3]);
    chk(!got_e && key == model_key(), "R5 new writer", key, model_key());
    bus(1, 0, 3'd5, 5'd0, 0);
    chk(got_d == 32'h8000_0000 && !got_e, "R8 readback any agent", got_d, 32'h8000_0000);
  endtask

  task automatic t_unmapped();
    for (int a = 6; a < 8; a++) begin
      bus(1, 0, 3'(a), 5'd15, 0);
      chk(got_e && got_d == 0, "R9 unmapped read", {got_d, got_e}, 1);
      bus(0, 1, 3'(a), 5'd31, 32'hFFFF_FFFF);
      chk(got_e && key == model_key(), "R9 unmapped write", key, model_key());
    end
  endtask

  task automatic t_both();
    exp_key[0] = 32'h1234_5678;
    bus(1, 1, 3'd0, 5'd31, exp_key[0]);
    chk(!got_e && got_d == 0, "R10 write wins, no data", {got_d, got_e}, 0);
    chk(key == model_key(), "R10 write landed", key, model_key());
    bus(1, 1, 3'd1, 5'd15, 32'h0);
    chk(got_e && got_d == 0 && key == model_key(), "R10 reader with both strobes refused", {got_d, got_e}, 1);
  endtask

  initial begin
    #100000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) exp_key[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_write_read();
    t_denied();
    t_sweep();
    t_policy_update();
    t_unmapped();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule